// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Translator

This block turns a 16-bit logical address into a 20-bit physical address. The logical space splits into four regions. The top 8K window, E000h to FFFFh, is fixed. Below it sit a stack region, a data region and a base region. Their limits come from two 4-bit fields of a boundary register, in 4K units. Each relocated region adds an 8-bit segment value, shifted left by twelve, to the logical address. The sum wraps modulo 1M. The base region passes through with no offset.

Translation is purely combinational: the physical address and the region code follow the logical input in the same cycle. Four 8-bit configuration registers hold the boundary, stack, data and window values. They are loaded through a single-cycle write port and cleared by reset. A write applies from the clock edge that captures it.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset all four configuration registers are zero. Every logical address below E000h maps to itself with zero-extension. E000h maps to 0E000h.
- R2: A logical address from E000h to FFFFh is in the window region, with region code 3. Its physical address is the logical address plus the window register shifted left by 12.
- R3: An address below E000h whose top nibble is at or above boundary bits [7:4] is in the stack region, with region code 2. The stack register shifted left by 12 is added.
- R4: An address in neither the window nor the stack region whose top nibble is at or above boundary bits [3:0] is in the data region, with region code 1. The data register shifted left by 12 is added.
- R5: Every other address is in the base region, with region code 0. Its physical address equals the logical address, zero-extended.
- R6: The sum is truncated to 20 bits and the carry out of bit 19 is lost. With the window register at F8h, E000h maps to 06000h and FFFFh maps to 07FFFh.
- R7: With boundary D6h, stack 92h and data 7Ah, D000h maps to 9F000h and 6000h maps to 80000h.
- R8: A write with wr_en high loads the register chosen by wr_sel: 0 is the boundary, 1 is the stack, 2 is the data and 3 is the window. The new value governs translation from the next cycle. The output follows log_addr within the same cycle.
- R9: If boundary bits [7:4] are lower than bits [3:0], an address at or above the stack limit still goes to the stack region. No error indication exists.
- R10: While wr_en is low, wr_sel and wr_data leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 boundary, 1 stack, 2 data, 3 window) |
| wr_data | input | 8 | Value to write |
| log_addr | input | 16 | Logical address |
| phys_addr | output | 20 | Translated physical address |
| region | output | 2 | Region code (0 base, 1 data, 2 stack, 3 window) |

## Verification
A corrupted configuration register shows at the ports on the first translation that falls in the affected region. It appears as a physical address shifted by a multiple of 4K, or as a wrong region code when the boundary is damaged. Because translation is combinational, the error is visible in the same cycle the address is applied. A write that fails to land, or one that lands without wr_en, is seen one cycle after the write edge.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int unsigned LA_W_DEF   = 16;
    localparam int unsigned PA_W_DEF   = 20;
    localparam int unsigned SEG_W_DEF  = 8;
    localparam int unsigned PG_SH_DEF  = 12;

    typedef enum logic [1:0] {
        SEL_BOUND  = 2'd0,
        SEL_STACK  = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_WINDOW = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        RGN_BASE   = 2'd0,
        RGN_DATA   = 2'd1,
        RGN_STACK  = 2'd2,
        RGN_WINDOW = 2'd3
    } region_e;

    typedef struct packed {
        logic [SEG_W_DEF-1:0] bound;
        logic [SEG_W_DEF-1:0] stack;
        logic [SEG_W_DEF-1:0] data;
        logic [SEG_W_DEF-1:0] window;
    } cfg_regs_t;

endpackage

// File: rtl/seg_xlate_cfg.sv
module seg_xlate_cfg
    import seg_xlate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output cfg_regs_t  regs
);

    cfg_regs_t regs_d;
    cfg_regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (cfg_sel_e'(wr_sel))
                SEL_BOUND:  regs_d.bound  = wr_data;
                SEL_STACK:  regs_d.stack  = wr_data;
                SEL_DATA:   regs_d.data   = wr_data;
                SEL_WINDOW: regs_d.window = wr_data;
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/seg_xlate_decode.sv
module seg_xlate_decode
    import seg_xlate_pkg::*;
#(
    parameter int unsigned PG_W     = 4,
    parameter int unsigned WIN_PAGE = 14
) (
    input  logic [PG_W-1:0] page,
    input  logic [PG_W-1:0] stack_lim,
    input  logic [PG_W-1:0] data_lim,
    output region_e         region
);

    localparam int unsigned LANES = 3;

    logic [PG_W-1:0]  thr [LANES];
    logic [LANES-1:0] hit;

    assign thr[0] = data_lim;
    assign thr[1] = stack_lim;
    assign thr[2] = PG_W'(WIN_PAGE);

    // One comparator per limit; the priority pick follows below.
    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_cmp
            assign hit[gi] = (page >= thr[gi]);
        end
    endgenerate

    always_comb begin
        if (hit[2]) begin
            region = RGN_WINDOW;
        end else if (hit[1]) begin
            region = RGN_STACK;
        end else if (hit[0]) begin
            region = RGN_DATA;
        end else begin
            region = RGN_BASE;
        end
    end

endmodule

// File: rtl/seg_xlate_reloc.sv
module seg_xlate_reloc
    import seg_xlate_pkg::*;
#(
    parameter int unsigned LA_W  = 16,
    parameter int unsigned PA_W  = 20,
    parameter int unsigned SEG_W = 8,
    parameter int unsigned PG_SH = 12
) (
    input  logic [LA_W-1:0]  log_addr,
    input  region_e          region,
    input  logic [SEG_W-1:0] stack_seg,
    input  logic [SEG_W-1:0] data_seg,
    input  logic [SEG_W-1:0] win_seg,
    output logic [PA_W-1:0]  phys_addr
);

    localparam int unsigned OFF_W = SEG_W + PG_SH;
    localparam int unsigned SUM_W = (OFF_W > PA_W) ? OFF_W + 1 : PA_W + 1;

    logic [SEG_W-1:0] seg_pick;
    logic [SUM_W-1:0] sum_full;

    always_comb begin
        unique case (region)
            RGN_WINDOW: seg_pick = win_seg;
            RGN_STACK:  seg_pick = stack_seg;
            RGN_DATA:   seg_pick = data_seg;
            default:    seg_pick = '0;
        endcase
    end

    // Wider sum, then truncate: the carry past PA_W is dropped.
    assign sum_full  = SUM_W'(log_addr) + (SUM_W'(seg_pick) << PG_SH);
    assign phys_addr = sum_full[PA_W-1:0];

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int unsigned LA_W     = 16,
    parameter int unsigned PA_W     = 20,
    parameter int unsigned PG_SH    = 12,
    parameter int unsigned WIN_PAGE = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [7:0]      wr_data,
    input  logic [LA_W-1:0] log_addr,
    output logic [PA_W-1:0] phys_addr,
    output logic [1:0]      region
);

    localparam int unsigned PG_W  = LA_W - PG_SH;
    localparam int unsigned SEG_W = SEG_W_DEF;

    cfg_regs_t regs;
    region_e   rgn;

    seg_xlate_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs    (regs)
    );

    seg_xlate_decode #(
        .PG_W     (PG_W),
        .WIN_PAGE (WIN_PAGE)
    ) u_dec (
        .page      (log_addr[LA_W-1 -: PG_W]),
        .stack_lim (regs.bound[SEG_W-1 -: PG_W]),
        .data_lim  (regs.bound[PG_W-1:0]),
        .region    (rgn)
    );

    seg_xlate_reloc #(
        .LA_W  (LA_W),
        .PA_W  (PA_W),
        .SEG_W (SEG_W),
        .PG_SH (PG_SH)
    ) u_rel (
        .log_addr  (log_addr),
        .region    (rgn),
        .stack_seg (regs.stack),
        .data_seg  (regs.data),
        .win_seg   (regs.window),
        .phys_addr (phys_addr)
    );

    assign region = rgn;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] log_addr,
    input logic [19:0] phys_addr,
    input logic [1:0]  region,
    input logic [7:0]  bound_v,
    input logic [7:0]  stack_v,
    input logic [7:0]  data_v,
    input logic [7:0]  win_v
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bound_v == 8'h0 && stack_v == 8'h0 && data_v == 8'h0 && win_v == 8'h0));

    // R2
    window_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_addr[15:13] == 3'b111) |-> (region == 2'd3));

    // R3
    stack_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 2'd2) |-> (phys_addr == 20'(log_addr + (20'(stack_v) << 12))));

    // R5
    base_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 2'd0) |-> (phys_addr == {4'h0, log_addr}));

    // R9
    stack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_addr[15:12] < 4'hE && log_addr[15:12] >= bound_v[7:4]) |-> (region == 2'd2));

    // R10
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bound_v) && $stable(stack_v) && $stable(data_v) && $stable(win_v)));

endmodule

bind seg_xlate_top seg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .log_addr  (log_addr),
    .phys_addr (phys_addr),
    .region    (region),
    .bound_v   (regs.bound),
    .stack_v   (regs.stack),
    .data_v    (regs.data),
    .win_v     (regs.window)
);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] log_addr = '0;
    logic [19:0] phys_addr;
    logic [1:0]  region;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [19:0] pa;
        logic [1:0]  rg;
        string       req;
    } exp_t;

    exp_t sbq[$];

    // Shadow of the configuration as the bench believes it to be.
    logic [7:0] m_bnd = 8'h0, m_stk = 8'h0, m_dat = 8'h0, m_win = 8'h0;

    always #10 clk = ~clk;

    seg_xlate_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .log_addr  (log_addr),
        .phys_addr (phys_addr),
        .region    (region)
    );

    function automatic exp_t model(input logic [15:0] la, input string req);
        exp_t e;
        logic [7:0] seg;
        if (la >= 16'hE000) begin
            e.rg = 2'd3; seg = m_win;
        end else if (la[15:12] >= m_bnd[7:4]) begin
            e.rg = 2'd2; seg = m_stk;
        end else if (la[15:12] >= m_bnd[3:0]) begin
            e.rg = 2'd1; seg = m_dat;
        end else begin
            e.rg = 2'd0; seg = 8'h0;
        end
        e.pa  = 20'({4'h0, la} + {seg, 12'h000});
        e.req = req;
        return e;
    endfunction

    task automatic translate(input logic [15:0] la, input string req);
        @(negedge clk);
        log_addr = la;
        sbq.push_back(model(la, req));
    endtask

    task automatic translate_fixed(input logic [15:0] la, input logic [19:0] pa,
                                   input logic [1:0] rg, input string req);
        exp_t e;
        @(negedge clk);
        log_addr = la;
        e.pa = pa; e.rg = rg; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: m_bnd = val;
            2'd1: m_stk = val;
            2'd2: m_dat = val;
            default: m_win = val;
        endcase
    endtask

    // Monitor: compares mid-low-phase, after the driver's update.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (phys_addr !== e.pa || region !== e.rg) begin
                    fails++;
                    $display("FAIL %s: la=%h pa=%h rg=%0d expected pa=%h rg=%0d",
                             e.req, log_addr, phys_addr, region, e.pa, e.rg);
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 identity after reset
        translate_fixed(16'h0000, 20'h00000, 2'd2, "R1");
        translate_fixed(16'h7ABC, 20'h07ABC, 2'd2, "R1");
        translate_fixed(16'hDFFF, 20'h0DFFF, 2'd2, "R1");
        translate_fixed(16'hE000, 20'h0E000, 2'd3, "R1");

        // R6 wrap with window F8h
        write_reg(2'd3, 8'hF8);
        translate_fixed(16'hE000, 20'h06000, 2'd3, "R6");
        translate_fixed(16'hFFFF, 20'h07FFF, 2'd3, "R6");
        translate(16'hF123, "R2");

        // R7 worked example
        write_reg(2'd0, 8'hD6);
        write_reg(2'd1, 8'h92);
        write_reg(2'd2, 8'h7A);
        translate_fixed(16'hD000, 20'h9F000, 2'd2, "R7");
        translate_fixed(16'h6000, 20'h80000, 2'd1, "R7");
        translate(16'hDFFF, "R3");
        translate(16'hCFFF, "R4");
        translate(16'h5FFF, "R5");
        translate(16'h0000, "R5");

        // R10 writes with strobe low do nothing
        @(negedge clk);
        wr_en = 1'b0;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            wr_sel = 2'(s); wr_data = 8'h11;
        end
        translate(16'hD234, "R10");
        translate(16'h6234, "R10");
        translate(16'hE234, "R10");
        translate(16'h1234, "R10");

        // R8 new value governs the next translation; same-cycle response
        write_reg(2'd1, 8'h05);
        translate(16'hD800, "R8");
        write_reg(2'd0, 8'h84);
        translate(16'h8000, "R8");
        translate(16'h7FFF, "R8");
        translate(16'h3FFF, "R8");

        // R9 inverted limits: stack limit 2, data limit 9
        write_reg(2'd0, 8'h29);
        translate(16'h2000, "R9");
        translate(16'hA000, "R9");
        translate(16'h1FFF, "R9");

        // Sweep of pages under a few configurations
        for (int c = 0; c < 3; c++) begin
            write_reg(2'd0, (c == 0) ? 8'h00 : (c == 1) ? 8'hEE : 8'hB3);
            write_reg(2'd2, 8'h40 + 8'(c));
            for (int p = 0; p < 16; p++) begin
                translate({4'(p), 12'h5A5}, (p >= 14) ? "R2" : "R4");
            end
        end

        @(negedge clk);
        @(negedge clk);
        #8;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule